// File: doc/BRIEF.md
# Card Receive FIFO with Masked Status Interrupt

This block buffers words arriving from the card data path of a host adapter until the system bus collects them. It holds up to 32 words of 32 bits each. The card side offers one word per cycle with a valid strobe. The bus side reads the head word combinationally on a read strobe, and the entry is retired at the next clock edge.

The block derives five status flags from its occupancy: full, empty, threshold (eight or more words stored), data available, and overrun. Overrun is sticky. A mask register selects which flags raise the single interrupt request. The threshold flag is also driven out as a DMA request, so a DMA engine can drain the FIFO in bursts. Writing the overrun bit of a write-only clear register drops the sticky overrun flag.

Top module: `card_rx_fifo`

## Requirements
- R1: Flag bit 0 (full) is high exactly when 32 words are stored.
- R2: Flag bit 1 (empty) is high exactly when no word is stored.
- R3: Flag bit 2 (threshold) is high exactly when 8 or more words are stored, and `dma_req_o` always equals it.
- R4: Flag bit 3 (data available) is always the inverse of flag bit 1.
- R5: Words are read out in the order they were accepted. `rd_data_o` shows the oldest stored word in the same cycle, and a read strobe retires that word at the clock edge.
- R6: A word offered while the FIFO is full is discarded. The stored words are unchanged, and flag bit 4 (overrun) is set.
- R7: Overrun stays set until a clear write has bit 4 high. A clear write with bit 4 low has no effect. A new overrun in the same cycle as a clear keeps the flag set.
- R8: A read while empty returns zero and retires nothing. The next word written is the next word read.
- R9: A simultaneous write and read on a FIFO that is neither empty nor full leaves the occupancy unchanged.
- R10: The mask register is 32-bit read/write and reads back on `mask_o`. `irq_o` is high exactly when some flag bit n (n = 0..4) and mask bit n are both high.
- R11: After reset the FIFO is empty, overrun is clear, the mask is zero, and `irq_o`, `dma_req_o` and `rd_data_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Card side offers a word |
| wr_data_i | input | 32 | Word from card side |
| rd_en_i | input | 1 | Bus read of the FIFO address |
| rd_data_o | output | 32 | Oldest word, or zero when empty |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask register write data |
| mask_o | output | 32 | Mask register readback |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 32 | Clear register write data (bit 4 clears overrun) |
| flags_o | output | 5 | {overrun, avail, threshold, empty, full} |
| irq_o | output | 1 | Masked interrupt request |
| dma_req_o | output | 1 | DMA request (threshold flag) |

## Verification
If the occupancy counter or a pointer is corrupted, the flags move to the wrong level within one clock after the faulty update. A skipped or doubled pointer step puts the wrong word on `rd_data_o` at the next read. The bench fills the FIFO one word at a time and drains it the same way, so every occupancy from 0 to 32 is compared against flags predicted from a bench-side queue. Overrun ordering and mask decoding only become visible on `flags_o[4]` and `irq_o`. For this reason the bench sweeps all 32 values of the low mask field against a known flag set and applies every clear and overrun combination.

// File: rtl/card_rx_fifo_pkg.sv
package card_rx_fifo_pkg;
  localparam int FLG_FULL  = 0;
  localparam int FLG_EMPTY = 1;
  localparam int FLG_THR   = 2;
  localparam int FLG_AVAIL = 3;
  localparam int FLG_OVR   = 4;
  localparam int NUM_FLAGS = 5;
endpackage

// File: rtl/rx_store.sv
module rx_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push, pop, is_full, is_empty;

  assign is_full  = (cnt_q == FULL_CNT);
  assign is_empty = (cnt_q == '0);
  assign push     = wr_i && !is_full;   // full-time writes are dropped
  assign pop      = rd_i && !is_empty;
  assign rdata_o  = is_empty ? '0 : mem_q[rptr_q];
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R6
  ovr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_full && !rd_i) |=> (cnt_q == FULL_CNT) && $stable(wptr_q));
  // R8
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_empty && !wr_i) |=> (cnt_q == '0) && $stable(rptr_q));
  // R9
  rw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !is_empty && !is_full) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_status.sv
module rx_status
  import card_rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 wr_i,
  input  logic                 clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THR_CNT  = CNT_W'(THRESH);

  logic ovr_q, new_ovr, full;

  assign full    = (count_i == FULL_CNT);
  assign new_ovr = wr_i && full;

  // new overrun beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (new_ovr) ovr_q <= 1'b1;
    else if (clr_i)   ovr_q <= 1'b0;
  end

  always_comb begin
    flags_o            = '0;
    flags_o[FLG_FULL]  = full;
    flags_o[FLG_EMPTY] = (count_i == '0);
    flags_o[FLG_THR]   = (count_i >= THR_CNT);
    flags_o[FLG_AVAIL] = (count_i != '0);
    flags_o[FLG_OVR]   = ovr_q;
  end

  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  // R7
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> !ovr_q);
endmodule

// File: rtl/rx_irq_mask.sv
module rx_irq_mask
  import card_rx_fifo_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [REG_W-1:0]     mask_o,
  output logic                 irq_o
);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(flags_i & mask_q[NUM_FLAGS-1:0]);

  // R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/card_rx_fifo.sv
module card_rx_fifo
  import card_rx_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int THRESH = 8,
  parameter int REG_W  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 rd_en_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 mask_we_i,
  input  logic [REG_W-1:0]     mask_wdata_i,
  output logic [REG_W-1:0]     mask_o,
  input  logic                 clr_we_i,
  input  logic [REG_W-1:0]     clr_wdata_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o,
  output logic                 dma_req_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             clr_ovr;

  assign clr_ovr = clr_we_i && clr_wdata_i[FLG_OVR];

  rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_i(wr_valid_i), .wdata_i(wr_data_i),
    .rd_i(rd_en_i), .rdata_o(rd_data_o),
    .count_o(count)
  );

  rx_status #(.DEPTH(DEPTH), .THRESH(THRESH)) u_status (
    .clk_i, .rst_ni,
    .count_i(count), .wr_i(wr_valid_i), .clr_i(clr_ovr),
    .flags_o(flags_o)
  );

  rx_irq_mask #(.REG_W(REG_W)) u_mask (
    .clk_i, .rst_ni,
    .we_i(mask_we_i), .wdata_i(mask_wdata_i),
    .flags_i(flags_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  assign dma_req_o = flags_o[FLG_THR];

  // R4
  avail_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_AVAIL] == !flags_o[FLG_EMPTY]);
  // R5
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_EMPTY] |-> (rd_data_o == '0));
endmodule

// File: tb/card_rx_fifo_bench.sv
module card_rx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int THRESH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic        mask_we_i = 1'b0, clr_we_i = 1'b0;
  logic [31:0] mask_wdata_i = '0, clr_wdata_i = '0, mask_o;
  logic [4:0]  flags_o;
  logic        irq_o, dma_req_o;

  int checks = 0, failures = 0;
  logic [31:0] q[$];
  logic        ovr_m = 1'b0;
  logic [31:0] mask_m = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  card_rx_fifo u_card_rx_fifo (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_flags();
    int n = q.size();
    return {ovr_m, n != 0, n >= THRESH, n == 0, n == DEPTH};
  endfunction

  task automatic check_all(string tag);
    logic [4:0] f = exp_flags();
    check({tag, " R1/R2/R3/R4/R6/R7 flags"}, 32'(flags_o), 32'(f));
    check({tag, " R3 dma"}, 32'(dma_req_o), 32'(f[2]));
    check({tag, " R10 irq"}, 32'(irq_o), 32'(|(f & mask_m[4:0])));
    check({tag, " R10 mask"}, mask_o, mask_m);
    check({tag, " R5/R8 rdata"}, rd_data_o, q.size() ? q[0] : 32'h0);
  endtask

  // drive at negedge, model at posedge, sample at next negedge
  task automatic cyc(logic wr, logic [31:0] wd, logic rd,
                     logic clr, logic [31:0] cw, logic mwe, logic [31:0] mw,
                     string tag);
    logic full_pre, nov;
    wr_valid_i = wr; wr_data_i = wd; rd_en_i = rd;
    clr_we_i = clr; clr_wdata_i = cw; mask_we_i = mwe; mask_wdata_i = mw;
    @(posedge clk_i);
    full_pre = (q.size() == DEPTH);
    nov = wr && full_pre;
    if (rd && q.size() > 0) void'(q.pop_front());
    if (wr && !full_pre) q.push_back(wd);
    if (nov) ovr_m = 1'b1;
    else if (clr && cw[4]) ovr_m = 1'b0;
    if (mwe) mask_m = mw;
    @(negedge clk_i);
    wr_valid_i = 0; rd_en_i = 0; clr_we_i = 0; mask_we_i = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check_all("R11 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R11 after release");

    // R1 R2 R3 fill sweep through every level
    for (int i = 0; i < DEPTH; i++)
      cyc(1, 32'hA000_0000 + 32'(i), 0, 0, 0, 0, 0, "fill R1/R3");

    // R6 overrun while full
    cyc(1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R6 overrun");
    // R7 clear with bit 4 low is ignored
    cyc(0, 0, 0, 1, 32'hFFFF_FFEF, 0, 0, "R7 clear bit low");
    // R7 new overrun wins over clear
    cyc(1, 32'hBAD0_0001, 0, 1, 32'h10, 0, 0, "R7 overrun vs clear");
    // R10 mask sweep with flags {ovr,avail,thr,full}
    for (int m = 0; m < 32; m++)
      cyc(0, 0, 0, 0, 0, 1, 32'h5A5A_5A40 | 32'(m), "R10 sweep");
    // R7 clear alone
    cyc(0, 0, 0, 1, 32'h10, 0, 0, "R7 clear");
    // read and write while full: write dropped, overrun again
    cyc(1, 32'hBAD0_0002, 1, 0, 0, 0, 0, "R6 full rw");
    cyc(0, 0, 0, 1, 32'h10, 0, 0, "R7 clear again");

    // R5 drain with order check at each level
    while (q.size() > 0) cyc(0, 0, 1, 0, 0, 0, 0, "drain R5/R2");

    // R8 empty read
    cyc(0, 0, 1, 0, 0, 1, 32'h2, "R8 empty read");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 empty read 2");
    cyc(1, 32'h1234_5678, 0, 0, 0, 0, 0, "R8 push");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 pop");

    // R9 simultaneous read/write at depth 3 and past threshold
    for (int i = 0; i < 3; i++) cyc(1, 32'hC000_0000 + 32'(i), 0, 0, 0, 0, 0, "R9 prime");
    for (int i = 0; i < 40; i++) cyc(1, 32'hC100_0000 + 32'(i), 1, 0, 0, 1, 32'h4, "R9 rw");
    check("R9 level", 32'(q.size()), 32'd3);
    for (int i = 0; i < 6; i++) cyc(1, 32'hC200_0000 + 32'(i), 0, 0, 0, 0, 0, "R9 grow");
    for (int i = 0; i < 20; i++) cyc(1, 32'hC300_0000 + 32'(i), 1, 0, 0, 0, 0, "R9 rw thr");
    while (q.size() > 0) cyc(0, 0, 1, 0, 0, 0, 0, "R5 final drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule